// File: doc/BRIEF.md
# Per-Rank DRAM Clock-Enable Power-Down Controller

This block drives the clock-enable line of every DRAM rank behind a memory controller and decides, rank by rank, when that line may drop. Each rank keeps its own idle counter. Any pending request or issued command to the rank clears that counter. Once the rank has been idle for a programmed number of cycles and nothing is pending for it, its CKE goes low and the rank enters power-down. A later request raises CKE again. The rank then reports not ready until a programmed exit delay has elapsed, and the scheduler must hold commands to that rank until ready returns.

A separate self-refresh request, raised while the package sits in a deep idle state, sends every eligible rank into self-refresh with CKE held low. A rank is eligible when it is not excluded by a per-rank mask (ranks in use by the graphics engine) and has nothing pending. A rank with pending work stays up until that work drains. A request to a rank in self-refresh aborts its stay, as does removal of the self-refresh request. The rank then follows the same exit delay as a wake from power-down.

Top module: `dram_cke_ctrl`

## Requirements
- R1: After reset every rank has cke_o high and ready_o high.
- R2: In normal operation a rank drops cke_o after idle_thresh_i consecutive clock edges at which neither req_i nor cmd_i was high for it. req_i or cmd_i restarts that count from zero. Each rank counts on its own.
- R3: An idle_thresh_i of zero disables idle power-down. With self-refresh not requested, cke_o then stays high.
- R4: A rank in power-down or self-refresh raises cke_o at the first edge that sees its wake condition. ready_o stays low for txp_i cycles after that edge and is high from the edge that ends them.
- R5: With txp_i zero, a waking rank raises ready_o at the same edge as cke_o.
- R6: While sr_req_i is high, a rank enters self-refresh at the next edge if its bit in sr_excl_i is low and it has no req_i or cmd_i. It may enter from normal operation or from power-down. Its cke_o then stays low for as long as sr_req_i stays high and no request arrives. When the idle threshold is reached at the same edge, self-refresh entry takes priority.
- R7: A rank whose sr_excl_i bit is high never enters self-refresh.
- R8: A rank with req_i high does not enter self-refresh. A req_i arriving in self-refresh wakes the rank as in R4, while the other ranks stay in self-refresh.
- R9: Dropping sr_req_i wakes every rank in self-refresh, each with the exit delay of R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_RANKS | Per-rank request pending |
| cmd_i | input | NUM_RANKS | Per-rank command issued this cycle |
| sr_req_i | input | 1 | Deep package idle: self-refresh wanted |
| sr_excl_i | input | NUM_RANKS | Ranks barred from self-refresh |
| idle_thresh_i | input | CNT_W | Idle cycles before power-down, 0 = off |
| txp_i | input | CNT_W | Exit delay in cycles |
| cke_o | output | NUM_RANKS | Clock enable per rank |
| ready_o | output | NUM_RANKS | Rank usable for commands |

## Verification
Two functions can meet at one edge. One rank can wake from self-refresh on a request while another rank's pending request drops and lets it enter self-refresh. Separately, a single rank can reach its idle threshold at the same edge that self-refresh becomes eligible. The directed part provokes the first case by swapping the request bits of two ranks between one cycle and the next, then checks the whole cke and ready vectors exactly. Random traffic with slowly toggled self-refresh and changing thresholds produces both cases many times. Each cycle is judged against a cycle model in the bench that applies self-refresh ahead of idle power-down.

// File: rtl/pd_pkg.sv
package pd_pkg;
  typedef enum logic [1:0] {
    RK_ACT  = 2'd0,
    RK_PD   = 2'd1,
    RK_SR   = 2'd2,
    RK_EXIT = 2'd3
  } rank_st_e;
endpackage

// File: rtl/pd_idle_cnt.sv
module pd_idle_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] thresh_i,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] CntMax = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_inc;

  assign cnt_inc  = {1'b0, cnt_q} + 1'b1;
  assign expire_o = !clr_i && (thresh_i != '0) && (cnt_inc >= {1'b0, thresh_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i)           cnt_q <= '0;
    else if (cnt_q != CntMax) cnt_q <= cnt_inc[CNT_W-1:0];
  end
endmodule

// File: rtl/pd_exit_tmr.sv
module pd_exit_tmr #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] txp_i,
  output logic             done_o
);
  logic [CNT_W-1:0] ecnt_q;

  assign done_o = (ecnt_q <= CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            ecnt_q <= '0;
    else if (load_i)        ecnt_q <= txp_i;
    else if (ecnt_q != '0)  ecnt_q <= ecnt_q - 1'b1;
  end
endmodule

// File: rtl/pd_rank_fsm.sv
module pd_rank_fsm
  import pd_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             cmd_i,
  input  logic             sr_req_i,
  input  logic             excl_i,
  input  logic [CNT_W-1:0] thresh_i,
  input  logic [CNT_W-1:0] txp_i,
  output logic             cke_o,
  output logic             ready_o
);
  rank_st_e state_q, state_d;
  logic     expire, exit_done, load_exit, sr_go, sr_wake, wake;

  pd_idle_cnt #(.CNT_W(CNT_W)) u_idle (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (req_i || cmd_i || (state_q != RK_ACT)),
    .thresh_i (thresh_i),
    .expire_o (expire)
  );

  pd_exit_tmr #(.CNT_W(CNT_W)) u_exit (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_exit),
    .txp_i  (txp_i),
    .done_o (exit_done)
  );

  // self-refresh needs an eligible rank with nothing pending
  assign sr_go   = sr_req_i && !excl_i && !req_i && !cmd_i;
  assign sr_wake = req_i || !sr_req_i || excl_i;
  assign wake    = ((state_q == RK_PD) && req_i) || ((state_q == RK_SR) && sr_wake);

  always_comb begin
    state_d   = state_q;
    load_exit = 1'b0;
    unique case (state_q)
      RK_ACT: begin
        if (sr_go)       state_d = RK_SR;
        else if (expire) state_d = RK_PD;
      end
      RK_PD: begin
        if (!req_i && sr_go) state_d = RK_SR;
      end
      RK_SR: ;
      RK_EXIT: begin
        if (exit_done) state_d = RK_ACT;
      end
      default: state_d = RK_ACT;
    endcase
    if (wake) begin
      load_exit = 1'b1;
      state_d   = (txp_i == '0) ? RK_ACT : RK_EXIT;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= RK_ACT;
    else         state_q <= state_d;
  end

  assign cke_o   = (state_q != RK_PD) && (state_q != RK_SR);
  assign ready_o = (state_q == RK_ACT);

  assert_no_pd_when_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cke_o) |-> ($past(sr_req_i) || ($past(thresh_i) != '0)));

  assert_exit_holds_ready_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cke_o) && ($past(txp_i) != '0)) |-> !ready_o);

  assert_ready_after_exit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> (($past(state_q) == RK_EXIT) || ($past(txp_i) == '0)));

  assert_zero_txp_ready_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cke_o) && ($past(txp_i) == '0)) |-> ready_o);

  assert_sr_excluded_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RK_SR) |-> !$past(excl_i));

  assert_sr_drained_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RK_SR) |-> (!$past(req_i) && $past(sr_req_i)));
endmodule

// File: rtl/dram_cke_ctrl.sv
module dram_cke_ctrl #(
  parameter int NUM_RANKS = 4,
  parameter int CNT_W     = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_RANKS-1:0] req_i,
  input  logic [NUM_RANKS-1:0] cmd_i,
  input  logic                 sr_req_i,
  input  logic [NUM_RANKS-1:0] sr_excl_i,
  input  logic [CNT_W-1:0]     idle_thresh_i,
  input  logic [CNT_W-1:0]     txp_i,
  output logic [NUM_RANKS-1:0] cke_o,
  output logic [NUM_RANKS-1:0] ready_o
);
  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    pd_rank_fsm #(.CNT_W(CNT_W)) u_rank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .req_i    (req_i[r]),
      .cmd_i    (cmd_i[r]),
      .sr_req_i (sr_req_i),
      .excl_i   (sr_excl_i[r]),
      .thresh_i (idle_thresh_i),
      .txp_i    (txp_i),
      .cke_o    (cke_o[r]),
      .ready_o  (ready_o[r])
    );
  end

  assert_ready_needs_cke_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o & ~cke_o) == '0);
endmodule

// File: tb/tb_dram_cke_ctrl.sv
`timescale 1ns/1ps
module tb_dram_cke_ctrl;
  localparam int N = 4;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0, cmd = '0, excl = '0;
  logic         sr = 1'b0;
  logic [W-1:0] thr = 8'd5, txp = 8'd3;
  logic [N-1:0] cke, rdy;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dram_cke_ctrl #(.NUM_RANKS(N), .CNT_W(W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .cmd_i(cmd), .sr_req_i(sr),
    .sr_excl_i(excl), .idle_thresh_i(thr), .txp_i(txp), .cke_o(cke), .ready_o(rdy)
  );

  // cycle model: 0 active, 1 power-down, 2 self-refresh, 3 exit wait
  int m_st[N], m_idle[N], m_ex[N];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < N; r++) begin m_st[r] = 0; m_idle[r] = 0; m_ex[r] = 0; end
    end else begin
      for (int r = 0; r < N; r++) begin
        bit go_sr, wk;
        go_sr = sr && !excl[r] && !req[r] && !cmd[r];
        wk = (m_st[r] == 1 && req[r]) || (m_st[r] == 2 && (req[r] || !sr || excl[r]));
        if (wk) begin
          m_idle[r] = 0;
          if (txp == 0) m_st[r] = 0; else begin m_st[r] = 3; m_ex[r] = txp; end
        end else begin
          case (m_st[r])
            0: if (go_sr) begin m_st[r] = 2; m_idle[r] = 0; end
               else if (req[r] || cmd[r]) m_idle[r] = 0;
               else if (thr != 0 && m_idle[r] + 1 >= thr) begin m_st[r] = 1; m_idle[r] = 0; end
               else if (m_idle[r] < 255) m_idle[r] = m_idle[r] + 1;
            1: if (go_sr) m_st[r] = 2;
            3: if (m_ex[r] <= 1) m_st[r] = 0; else m_ex[r] = m_ex[r] - 1;
            default: ;
          endcase
        end
      end
    end
  end

  function automatic logic [N-1:0] exp_cke();
    logic [N-1:0] v;
    for (int r = 0; r < N; r++) v[r] = (m_st[r] != 1) && (m_st[r] != 2);
    return v;
  endfunction

  function automatic logic [N-1:0] exp_rdy();
    logic [N-1:0] v;
    for (int r = 0; r < N; r++) v[r] = (m_st[r] == 0);
    return v;
  endfunction

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h1bad_5eed));
    tick(2);
    rst_n = 1'b1;
    chk("R1 cke after reset", cke, 4'hF);
    chk("R1 ready after reset", rdy, 4'hF);

    // R2: rank 1 gets one command, others idle from here
    cmd = 4'b0010;
    tick(1);
    cmd = '0;
    tick(4);
    chk("R2 idle ranks drop cke", cke, 4'b0010);
    tick(1);
    chk("R2 commanded rank drops one cycle later", cke, 4'b0000);

    // R4: wake rank 0, exit delay 3
    req = 4'b0001;
    tick(1);
    chk("R4 cke on wake", cke, 4'b0001);
    chk("R4 ready held", rdy, 4'b0000);
    tick(2);
    chk("R4 ready still held", rdy, 4'b0000);
    tick(1);
    chk("R4 ready after txp", rdy, 4'b0001);

    // R3: threshold zero keeps every rank up
    thr = '0;
    req = 4'hF;
    tick(4);
    chk("R3 all ready", rdy, 4'hF);
    req = '0;
    tick(20);
    chk("R3 no power-down with zero threshold", cke, 4'hF);

    // R6, R7, R8: rank 2 excluded, rank 3 pending
    excl = 4'b0100;
    req  = 4'b1000;
    sr   = 1'b1;
    tick(1);
    chk("R6 R7 R8 self-refresh entry", cke, 4'b1100);
    tick(5);
    chk("R6 cke held low in self-refresh", cke, 4'b1100);
    req = 4'b0001;
    tick(1);
    chk("R8 abort on rank 0 while rank 3 enters", cke, 4'b0101);
    chk("R8 aborted rank waits exit delay", rdy, 4'b0100);
    tick(3);
    chk("R8 aborted rank ready", rdy, 4'b0101);

    // R9: drop self-refresh request
    req = '0;
    sr  = 1'b0;
    tick(1);
    chk("R9 cke restored", cke, 4'hF);
    chk("R9 exit delay applies", rdy, 4'b0101);
    tick(3);
    chk("R9 ready after exit delay", rdy, 4'hF);
    excl = '0;

    // R5: zero exit delay
    thr = 8'd3;
    tick(10);
    chk("R2 all ranks powered down", cke, 4'h0);
    txp = '0;
    req = 4'b0010;
    tick(1);
    chk("R5 cke with zero txp", cke, 4'b0010);
    chk("R5 ready with zero txp", rdy, 4'b0010);
    req = '0;
    txp = 8'd2;

    // random traffic against the cycle model (R2 R4 R6 R8 R9 interplay)
    for (int i = 0; i < 3000; i++) begin
      tick(1);
      chk("R6 R8 random cke vs model", cke, exp_cke());
      chk("R4 random ready vs model", rdy, exp_rdy());
      for (int r = 0; r < N; r++) begin
        req[r] = ($urandom % 100) < 4;
        cmd[r] = rdy[r] && (($urandom % 100) < 6);
      end
      if (($urandom % 100) < 3) sr = ~sr;
      if (($urandom % 200) < 1) excl = N'($urandom);
      if (($urandom % 300) < 1) thr = W'($urandom % 13);
      if (($urandom % 300) < 1) txp = W'($urandom % 6);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule